// File: doc/BRIEF.md
# Loopback Slave Transmit Controller

This block sits in the transmit path of a single-lane PHY with a parallel MAC interface. Each clock it chooses what the serializer gets. In normal operation that is the MAC's transmit byte and K flag. During loopback it is the byte and K flag from the receive path. It also drives the transmitter's electrical-idle indication. The receive stream is passed on to the MAC in every state, so the MAC can watch the traffic while the PHY echoes it.

Loopback starts only when the power state is fully on and the MAC raises its combined detect/loopback request. To end loopback, the MAC drops that request and raises its transmit-idle request. The controller then keeps echoing for a fixed number of bytes. This lets the far end's electrical-idle ordered set be forwarded in part before the transmitter goes quiet. The controller leaves electrical idle, and returns to normal, once the idle request is withdrawn. All outputs are registered, so a change of data source always lands on a whole-symbol clock boundary.

Top module: `lpbk_tx_ctrl`

## Requirements
- R1: After reset the transmit data and K outputs are 0, the electrical-idle output is 1, and the receive outputs to the MAC are 0.
- R2: A clock edge that samples power state 2'b00 (fully on) with the loopback request high, while in normal operation, starts loopback. The next edge already transmits received data.
- R3: A loopback request sampled with any power state other than 2'b00 is ignored. The next edge still transmits the MAC byte.
- R4: During loopback, each edge puts onto the transmit outputs the receive byte and K flag sampled at that edge, and ignores the MAC bus.
- R5: Every edge, in every state, puts onto the MAC receive outputs the receive byte and K flag sampled at that edge.
- R6: While looping back, dropping the loopback request with the idle request low keeps loopback. Raising the idle request with the loopback request still high also keeps loopback.
- R7: An edge that samples the loopback request low and the idle request high during loopback is followed by exactly DRAIN_BYTES (3) more edges that transmit received data, whatever the inputs. The edge after those sets electrical idle.
- R8: While electrical idle is set, the transmit data and K outputs are 0. After a drain, electrical idle holds until an edge samples the idle request low. The edge after that returns to normal operation, and the loopback request is ignored until then.
- R9: In normal operation each edge transmits the MAC byte and K flag sampled at that edge, and sets the electrical-idle output to the sampled idle request. When the idle request is high, the data and K outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_state_i | input | 2 | Power state; 2'b00 is fully on |
| lpbk_req_i | input | 1 | Combined detect/loopback request from the MAC |
| tx_idle_req_i | input | 1 | Transmit electrical-idle request from the MAC |
| mac_tx_data_i | input | 8 | MAC transmit byte |
| mac_tx_k_i | input | 1 | MAC transmit K flag |
| rx_data_i | input | 8 | Received byte from the receive path |
| rx_k_i | input | 1 | Received K flag |
| tx_data_o | output | 8 | Byte to the serializer |
| tx_k_o | output | 1 | K flag to the serializer |
| tx_elec_idle_o | output | 1 | Transmitter electrical-idle indication |
| mac_rx_data_o | output | 8 | Received byte presented to the MAC |
| mac_rx_k_o | output | 1 | Received K flag presented to the MAC |

## Verification
The bench drives a loopback request in every low-power state. A design that ignores the power state would echo receive data there. It ends loopback with the exit condition held for a single cycle, and also with the inputs changing during the drain. A miscounted drain shows up as two or four echoed bytes, or as a drain that hangs on the inputs. It raises the idle request and drops the loopback request one at a time during loopback. A design that exits on only one of them would go idle too early. It holds the loopback request high through electrical idle, which catches a design that jumps from idle straight back into loopback.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_LPBK   = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_IDLE   = 2'd3
  } lpbk_state_e;
endpackage

// File: rtl/lpbk_fsm.sv
module lpbk_fsm
  import lpbk_pkg::*;
#(
  parameter int          PWR_W       = 2,
  parameter logic [PWR_W-1:0] PWR_ON = '0,
  parameter int          DRAIN_BYTES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PWR_W-1:0] pwr_state_i,
  input  logic             lpbk_req_i,
  input  logic             tx_idle_req_i,
  output logic             sel_rx_o,
  output logic             force_idle_o
);
  localparam int CNT_W = $clog2(DRAIN_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_BYTES - 1);

  lpbk_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: if (pwr_state_i == PWR_ON && lpbk_req_i) state_d = ST_LPBK;
      ST_LPBK: if (!lpbk_req_i && tx_idle_req_i) begin
        state_d = ST_DRAIN;
        cnt_d   = '0;
      end
      ST_DRAIN: begin
        if (cnt_q == CNT_LAST) state_d = ST_IDLE;
        else cnt_d = cnt_q + 1'b1;
      end
      ST_IDLE: if (!tx_idle_req_i) state_d = ST_NORMAL;
      default: state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sel_rx_o     = (state_q == ST_LPBK) || (state_q == ST_DRAIN);
  assign force_idle_o = (state_q == ST_IDLE) || (state_q == ST_NORMAL && tx_idle_req_i);

  AST_ENTER_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && pwr_state_i == PWR_ON && lpbk_req_i) |=> state_q == ST_LPBK); // R2
  AST_NO_ENTER_LOWPWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NORMAL && pwr_state_i != PWR_ON) |=> state_q != ST_LPBK); // R3
  AST_NO_SKIP_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LPBK |=> state_q != ST_IDLE); // R7
  AST_DRAIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DRAIN |-> cnt_q <= CNT_LAST); // R7
  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_NORMAL)); // R8
endmodule

// File: rtl/lpbk_tx_mux.sv
module lpbk_tx_mux #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_rx_i,
  input  logic              force_idle_i,
  input  logic [DATA_W-1:0] mac_data_i,
  input  logic              mac_k_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_k_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_k_o,
  output logic              tx_idle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o <= '0;
      tx_k_o    <= 1'b0;
      tx_idle_o <= 1'b1;
    end else if (sel_rx_i) begin
      tx_data_o <= rx_data_i;
      tx_k_o    <= rx_k_i;
      tx_idle_o <= 1'b0;
    end else if (force_idle_i) begin
      tx_data_o <= '0;
      tx_k_o    <= 1'b0;
      tx_idle_o <= 1'b1;
    end else begin
      tx_data_o <= mac_data_i;
      tx_k_o    <= mac_k_i;
      tx_idle_o <= 1'b0;
    end
  end

  AST_ECHO_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rx_i |=> (tx_data_o == $past(rx_data_i) && tx_k_o == $past(rx_k_i))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> (tx_data_o == '0 && !tx_k_o)); // R8
endmodule

// File: rtl/lpbk_rx_pass.sv
module lpbk_rx_pass #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_k_i,
  output logic [DATA_W-1:0] mac_data_o,
  output logic              mac_k_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mac_data_o <= '0;
      mac_k_o    <= 1'b0;
    end else begin
      mac_data_o <= rx_data_i;
      mac_k_o    <= rx_k_i;
    end
  end

  AST_RX_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mac_data_o == $past(rx_data_i) && mac_k_o == $past(rx_k_i))); // R5
endmodule

// File: rtl/lpbk_tx_ctrl.sv
module lpbk_tx_ctrl #(
  parameter int DATA_W      = 8,
  parameter int PWR_W       = 2,
  parameter int DRAIN_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PWR_W-1:0]  pwr_state_i,
  input  logic              lpbk_req_i,
  input  logic              tx_idle_req_i,
  input  logic [DATA_W-1:0] mac_tx_data_i,
  input  logic              mac_tx_k_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_k_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_k_o,
  output logic              tx_elec_idle_o,
  output logic [DATA_W-1:0] mac_rx_data_o,
  output logic              mac_rx_k_o
);
  logic sel_rx, force_idle;

  lpbk_fsm #(
    .PWR_W(PWR_W), .PWR_ON('0), .DRAIN_BYTES(DRAIN_BYTES)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_state_i(pwr_state_i),
    .lpbk_req_i(lpbk_req_i), .tx_idle_req_i(tx_idle_req_i),
    .sel_rx_o(sel_rx), .force_idle_o(force_idle)
  );

  lpbk_tx_mux #(.DATA_W(DATA_W)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_rx_i(sel_rx), .force_idle_i(force_idle),
    .mac_data_i(mac_tx_data_i), .mac_k_i(mac_tx_k_i),
    .rx_data_i(rx_data_i), .rx_k_i(rx_k_i),
    .tx_data_o(tx_data_o), .tx_k_o(tx_k_o), .tx_idle_o(tx_elec_idle_o)
  );

  lpbk_rx_pass #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_data_i(rx_data_i), .rx_k_i(rx_k_i),
    .mac_data_o(mac_rx_data_o), .mac_k_o(mac_rx_k_o)
  );

  AST_LOWPWR_MAC_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i != '0 && !tx_elec_idle_o && tx_data_o == mac_tx_data_i && !sel_rx && !force_idle)
    |=> (tx_data_o == $past(mac_tx_data_i))); // R3
endmodule

// File: tb/sim_lpbk_tx_ctrl.sv
module sim_lpbk_tx_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwr;
  logic req, idl, mk, rk;
  logic [7:0] md, rd;
  logic [7:0] tx_d, mrx_d;
  logic tx_k, tx_ei, mrx_k;

  int checks = 0;
  int fails  = 0;
  int m_st   = 0;   // 0 normal, 1 loopback, 2 drain, 3 idle
  int m_cnt  = 0;

  always #2 clk = ~clk;

  lpbk_tx_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_state_i(pwr), .lpbk_req_i(req),
    .tx_idle_req_i(idl), .mac_tx_data_i(md), .mac_tx_k_i(mk),
    .rx_data_i(rd), .rx_k_i(rk), .tx_data_o(tx_d), .tx_k_o(tx_k),
    .tx_elec_idle_o(tx_ei), .mac_rx_data_o(mrx_d), .mac_rx_k_o(mrx_k)
  );

  task automatic check(input string rq, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] p, input logic q, input logic i,
                      input logic [7:0] a, input logic ak, input logic [7:0] b, input logic bk,
                      input string tag);
    logic [9:0] exp_tx;
    string rq;
    @(negedge clk);
    pwr = p; req = q; idl = i; md = a; mk = ak; rd = b; rk = bk;
    @(posedge clk);
    if (m_st == 1 || m_st == 2) begin
      exp_tx = {1'b0, bk, b}; rq = (m_st == 1) ? "R4" : "R7";
    end else if (m_st == 3 || (m_st == 0 && i)) begin
      exp_tx = {1'b1, 9'h0}; rq = (m_st == 3) ? "R8" : "R9";
    end else begin
      exp_tx = {1'b0, ak, a}; rq = (p != 2'b00 && q) ? "R3" : "R9";
    end
    case (m_st)
      0: if (p == 2'b00 && q) m_st = 1;
      1: if (!q && i) begin m_st = 2; m_cnt = 0; end
      2: if (m_cnt == 2) m_st = 3; else m_cnt++;
      default: if (!i) m_st = 0;
    endcase
    #1;
    check({rq, tag}, {tx_ei, tx_k, tx_d}, exp_tx);
    check({"R5", tag}, {1'b0, mrx_k, mrx_d}, {1'b0, bk, b});
  endtask

  task automatic rstep(input logic [1:0] p, input logic q, input logic i, input string tag);
    step(p, q, i, 8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), tag);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    pwr = 2'b00; req = 1'b0; idl = 1'b0; md = 8'h00; mk = 1'b0; rd = 8'h5A; rk = 1'b1;
    #10;
    check("R1 reset", {tx_ei, tx_k, tx_d}, {1'b1, 9'h0});
    check("R1 reset rx", {1'b0, mrx_k, mrx_d}, 10'h0);
    @(negedge clk); rst_n = 1'b1;
    // R9 normal flow
    for (int n = 0; n < 4; n++) rstep(2'b00, 1'b0, 1'b0, " normal");
    rstep(2'b00, 1'b0, 1'b1, " normal idle");
    // R3 request in each low-power state
    for (int p = 1; p < 4; p++) begin
      rstep(2'(p), 1'b1, 1'b0, " lowpwr req");
      rstep(2'(p), 1'b1, 1'b0, " lowpwr req");
    end
    // R2 enter, R4 echo
    rstep(2'b00, 1'b1, 1'b0, " enter");
    for (int n = 0; n < 3; n++) rstep(2'b00, 1'b1, 1'b0, " echo");
    // R6 half exits
    rstep(2'b00, 1'b0, 1'b0, " req drop only");
    rstep(2'b00, 1'b1, 1'b1, " idle only");
    rstep(2'b01, 1'b0, 1'b0, " stay");
    // R7 single-cycle exit, then inputs churn in drain
    rstep(2'b00, 1'b0, 1'b1, " exit");
    rstep(2'b00, 1'b1, 1'b0, " drain1");
    rstep(2'b10, 1'b1, 1'b0, " drain2");
    rstep(2'b00, 1'b0, 1'b0, " drain3");
    // R8 idle held while request high, leaves on idle drop
    rstep(2'b00, 1'b1, 1'b1, " idle hold");
    rstep(2'b00, 1'b1, 1'b1, " idle hold");
    rstep(2'b00, 1'b1, 1'b0, " idle leave");
    rstep(2'b00, 1'b0, 1'b0, " back normal");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] p;
      p = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      rstep(p, ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0), " random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule